// File: doc/BRIEF.md
# Waveform Accumulation Sequencer

This block runs the acquisition side of a digital signal averager. On a start command it waits a fixed delay. It then sends an arm pulse to an external waveform recorder and waits for the recorder's busy indicator to rise and then fall. After that it raises an output-request line that asks the recorder to stream its stored samples. Each sample is presented with a data-valid flag. The sequencer waits a short latch delay, then either adds the zero-extended sample to the word at the current address of a 16-bit accumulation memory or writes the sample over that word. It pulses a write strobe together with a fetch-next strobe back to the recorder. It then advances the address and ignores the flag for a settle holdoff.

When the address passes the last word of the active length, the scan is over. The address returns to zero and the output request drops. The recorder is re-armed after the same start delay, unless the configured number of scans has been accumulated. In that case the sequencer goes idle and raises a transfer request for a downstream transfer engine. The memory sits outside the block and is read one cycle after its address is presented. All delays and pulse widths are parameters counted in clock cycles.

Top module: `wavacc_seq`

## Requirements
- R1: After reset, ready_o is 1; arm_o, outreq_o, mem_we_o, fetch_o and xfer_req_o are 0; mem_addr_o is 0.
- R2: A start_i pulse is accepted only while idle and with attn_i low. With attn_i high the pulse is ignored: ready_o stays 1 and no arm pulse follows.
- R3: An accepted start is followed by ARM_DLY_CYC cycles of delay, then by arm_o high for exactly ARM_W_CYC cycles.
- R4: After the arm pulse the block waits for rec_busy_i to go high and then low. outreq_o goes high in the cycle after the low level is sampled and stays high for the whole scan.
- R5: While output is requested, flag_i high starts a word. LATCH_CYC cycles later the sample is captured, and mem_wdata_o becomes mem_rdata_i plus the zero-extended 6-bit sample, modulo 2^16, for the current mem_addr_o.
- R6: With overwrite_i high, mem_wdata_o is the zero-extended sample alone.
- R7: mem_we_o and fetch_o are high together for exactly WRITE_CYC cycles per word.
- R8: After each write the address increments by one. flag_i is then ignored for HOLD_CYC cycles, so with the flag already high the low gap between two writes of a scan is HOLD_CYC+LATCH_CYC+1 cycles.
- R9: The active length is 2^ADDR_W shifted right by size_sel_i (0: full, 1: half, 2: quarter, 3: eighth). After the last word, the address returns to 0 and outreq_o drops in the same cycle. If more scans remain, arm_o rises ARM_DLY_CYC cycles later.
- R10: The scan count is preset to one on each accepted start. After scan number SCAN_LIMIT, no re-arm occurs. xfer_req_o rises in the cycle outreq_o drops and holds until the next accepted start clears it.
- R11: ready_o is 1 exactly while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run start command |
| attn_i | input | 1 | Attention hold; blocks start |
| size_sel_i | input | 2 | Active memory length select |
| overwrite_i | input | 1 | Store sample instead of sum |
| rec_busy_i | input | 1 | Recorder capture in progress |
| flag_i | input | 1 | Recorder data-valid flag |
| sample_i | input | SAMP_W | Recorder sample |
| arm_o | output | 1 | Arm pulse to recorder |
| outreq_o | output | 1 | Output request to recorder |
| fetch_o | output | 1 | Fetch-next-word strobe |
| mem_addr_o | output | ADDR_W | Accumulation memory address |
| mem_rdata_i | input | DATA_W | Memory read data (one cycle latency) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Memory write data |
| xfer_req_o | output | 1 | Transfer request after last scan |
| ready_o | output | 1 | Idle and able to start |

## Verification
A corrupted address counter shows at the very next write strobe as a wrong mem_addr_o. It can also show as an output request that ends one word early or late, and the scoreboard catches that at the end of the scan. A wrong timer load shows in the first arm pulse or the first write, as a width or gap that is off by some number of cycles. A wrong scan count shows only at the end of the run, as a re-arm where a transfer request was due or the reverse. A datapath fault shows in the written word in the cycle the write strobe rises.

// File: rtl/wavacc_pkg.sv
package wavacc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM_DLY,
        S_ARM,
        S_WAIT_REC,
        S_REC,
        S_ACC,
        S_LATCH,
        S_WRITE,
        S_HOLD
    } seq_state_t;

endpackage

// File: rtl/wavacc_addr.sv
module wavacc_addr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [1:0]        size_sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int unsigned N_SIZES = 4;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] last_tab [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_len
        assign last_tab[g] = {ADDR_W{1'b1}} >> g;
    end

    assign last_o = (addr_q == last_tab[size_sel_i]);
    assign addr_o = addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr_i) begin
            addr_d = '0;
        end else if (step_i) begin
            addr_d = last_o ? '0 : addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R8: a mid-scan step moves exactly one word forward
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !last_o) |=> (addr_o == $past(addr_o) + 1'b1));

    // R9: stepping off the last active word returns to zero
    p_addr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_o) |=> (addr_o == '0));

endmodule

// File: rtl/wavacc_scan.sv
module wavacc_scan #(
    parameter int unsigned SCAN_LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam int unsigned CNT_W = $clog2(SCAN_LIMIT + 1);

    logic [CNT_W-1:0] scan_d, scan_q;

    assign at_limit_o = (scan_q == CNT_W'(SCAN_LIMIT));

    always_comb begin
        scan_d = scan_q;
        if (preset_i)   scan_d = CNT_W'(1);
        else if (inc_i) scan_d = scan_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= CNT_W'(1);
        else        scan_q <= scan_d;
    end

    // R10: the count never leaves 1..SCAN_LIMIT
    p_scan_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q != '0) && (scan_q <= CNT_W'(SCAN_LIMIT)));

endmodule

// File: rtl/wavacc_merge.sv
module wavacc_merge #(
    parameter int unsigned SAMP_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              overwrite_i,
    input  logic [SAMP_W-1:0] sample_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] wdata_o
);

    logic [DATA_W-1:0] ext_sample;
    logic [DATA_W-1:0] wdata_d, wdata_q;

    assign ext_sample = DATA_W'(sample_i);
    assign wdata_o    = wdata_q;

    always_comb begin
        wdata_d = wdata_q;
        if (load_i) begin
            wdata_d = overwrite_i ? ext_sample : rdata_i + ext_sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdata_q <= '0;
        else        wdata_q <= wdata_d;
    end

    // R6: an overwrite capture leaves nothing above the sample width
    p_ovw_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && overwrite_i) |=> (wdata_o >> SAMP_W) == '0);

endmodule

// File: rtl/wavacc_seq.sv
module wavacc_seq
    import wavacc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SAMP_W      = 6,
    parameter int unsigned SCAN_LIMIT  = 512,
    parameter int unsigned ARM_DLY_CYC = 100,
    parameter int unsigned ARM_W_CYC   = 15,
    parameter int unsigned LATCH_CYC   = 10,
    parameter int unsigned WRITE_CYC   = 20,
    parameter int unsigned HOLD_CYC    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              attn_i,
    input  logic [1:0]        size_sel_i,
    input  logic              overwrite_i,
    input  logic              rec_busy_i,
    input  logic              flag_i,
    input  logic [SAMP_W-1:0] sample_i,
    output logic              arm_o,
    output logic              outreq_o,
    output logic              fetch_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              xfer_req_o,
    output logic              ready_o
);

    localparam int unsigned M_A   = (ARM_DLY_CYC > ARM_W_CYC) ? ARM_DLY_CYC : ARM_W_CYC;
    localparam int unsigned M_B   = (LATCH_CYC > WRITE_CYC) ? LATCH_CYC : WRITE_CYC;
    localparam int unsigned M_C   = (M_A > M_B) ? M_A : M_B;
    localparam int unsigned T_MAX = (M_C > HOLD_CYC) ? M_C : HOLD_CYC;
    localparam int unsigned TMR_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_t       state;
        logic [TMR_W-1:0] tmr;
        logic             xfer;
    } seq_t;

    seq_t fsm_d, fsm_q;

    logic addr_clr, addr_step, addr_last;
    logic scan_preset, scan_inc, scan_at_limit;
    logic cap_load;

    wavacc_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (addr_clr),
        .step_i     (addr_step),
        .size_sel_i (size_sel_i),
        .addr_o     (mem_addr_o),
        .last_o     (addr_last)
    );

    wavacc_scan #(.SCAN_LIMIT(SCAN_LIMIT)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_i   (scan_preset),
        .inc_i      (scan_inc),
        .at_limit_o (scan_at_limit)
    );

    wavacc_merge #(.SAMP_W(SAMP_W), .DATA_W(DATA_W)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cap_load),
        .overwrite_i (overwrite_i),
        .sample_i    (sample_i),
        .rdata_i     (mem_rdata_i),
        .wdata_o     (mem_wdata_o)
    );

    always_comb begin
        fsm_d       = fsm_q;
        addr_clr    = 1'b0;
        addr_step   = 1'b0;
        scan_preset = 1'b0;
        scan_inc    = 1'b0;
        cap_load    = 1'b0;
        unique case (fsm_q.state)
            S_IDLE: begin
                if (start_i && !attn_i) begin
                    fsm_d.state = S_ARM_DLY;
                    fsm_d.tmr   = TMR_W'(ARM_DLY_CYC - 1);
                    fsm_d.xfer  = 1'b0;
                    scan_preset = 1'b1;
                    addr_clr    = 1'b1;
                end
            end
            S_ARM_DLY: begin
                if (fsm_q.tmr == '0) begin
                    fsm_d.state = S_ARM;
                    fsm_d.tmr   = TMR_W'(ARM_W_CYC - 1);
                end else begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end
            end
            S_ARM: begin
                if (fsm_q.tmr == '0) fsm_d.state = S_WAIT_REC;
                else                 fsm_d.tmr   = fsm_q.tmr - 1'b1;
            end
            S_WAIT_REC: begin
                if (rec_busy_i) fsm_d.state = S_REC;
            end
            S_REC: begin
                if (!rec_busy_i) fsm_d.state = S_ACC;
            end
            S_ACC: begin
                if (flag_i) begin
                    fsm_d.state = S_LATCH;
                    fsm_d.tmr   = TMR_W'(LATCH_CYC - 1);
                end
            end
            S_LATCH: begin
                if (fsm_q.tmr == '0) begin
                    cap_load    = 1'b1;
                    fsm_d.state = S_WRITE;
                    fsm_d.tmr   = TMR_W'(WRITE_CYC - 1);
                end else begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end
            end
            S_WRITE: begin
                if (fsm_q.tmr == '0) begin
                    addr_step = 1'b1;
                    if (addr_last) begin
                        if (scan_at_limit) begin
                            fsm_d.state = S_IDLE;
                            fsm_d.xfer  = 1'b1;
                        end else begin
                            scan_inc    = 1'b1;
                            fsm_d.state = S_ARM_DLY;
                            fsm_d.tmr   = TMR_W'(ARM_DLY_CYC - 1);
                        end
                    end else begin
                        fsm_d.state = S_HOLD;
                        fsm_d.tmr   = TMR_W'(HOLD_CYC - 1);
                    end
                end else begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end
            end
            S_HOLD: begin
                if (fsm_q.tmr == '0) fsm_d.state = S_ACC;
                else                 fsm_d.tmr   = fsm_q.tmr - 1'b1;
            end
            default: fsm_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= S_IDLE;
            fsm_q.tmr   <= '0;
            fsm_q.xfer  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign arm_o      = (fsm_q.state == S_ARM);
    assign outreq_o   = (fsm_q.state == S_ACC) || (fsm_q.state == S_LATCH) ||
                        (fsm_q.state == S_WRITE) || (fsm_q.state == S_HOLD);
    assign mem_we_o   = (fsm_q.state == S_WRITE);
    assign fetch_o    = (fsm_q.state == S_WRITE);
    assign xfer_req_o = fsm_q.xfer;
    assign ready_o    = (fsm_q.state == S_IDLE);

    // R2: start under attention leaves the block idle
    p_attn_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && attn_i) |=> ready_o);

    // R3: the arm pulse only begins after the delay phase
    p_arm_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_o) |-> ($past(fsm_q.state) == S_ARM_DLY));

    // R7: memory writes happen only inside an output request
    p_we_in_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> outreq_o);

    // R10: a pending transfer request implies the sequencer is idle
    p_xfer_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> ready_o);

endmodule

// File: tb/wavacc_seq_bench.sv
module wavacc_seq_bench;

    localparam int AW    = 7;
    localparam int DW    = 16;
    localparam int SW    = 6;
    localparam int LIM   = 3;
    localparam int T_DLY = 5;
    localparam int T_ARM = 3;
    localparam int T_LAT = 2;
    localparam int T_WR  = 3;
    localparam int T_HLD = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, attn, overwrite, rec_busy, flag;
    logic [1:0]    size_sel;
    logic [SW-1:0] sample;
    logic          arm, outreq, fetch, we, xfer, ready;
    logic [AW-1:0] addr;
    logic [DW-1:0] rdata, wdata;

    always #5 clk = ~clk;

    wavacc_seq #(
        .ADDR_W(AW), .DATA_W(DW), .SAMP_W(SW), .SCAN_LIMIT(LIM),
        .ARM_DLY_CYC(T_DLY), .ARM_W_CYC(T_ARM), .LATCH_CYC(T_LAT),
        .WRITE_CYC(T_WR), .HOLD_CYC(T_HLD)
    ) u_wavacc_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .attn_i(attn),
        .size_sel_i(size_sel), .overwrite_i(overwrite), .rec_busy_i(rec_busy),
        .flag_i(flag), .sample_i(sample), .arm_o(arm), .outreq_o(outreq),
        .fetch_o(fetch), .mem_addr_o(addr), .mem_rdata_i(rdata),
        .mem_we_o(we), .mem_wdata_o(wdata), .xfer_req_o(xfer), .ready_o(ready)
    );

    // synchronous accumulation memory, one-cycle read latency
    logic [DW-1:0] ram [DEPTH] = '{default: '0};
    always @(posedge clk) begin
        if (we) ram[addr] <= wdata;
        rdata <= ram[addr];
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        int      a;
        int      d;
        bit      ovw;
    } exp_t;
    exp_t          sb_q [$];
    logic [DW-1:0] model [DEPTH] = '{default: '0};

    // monitor: compares each write against the scoreboard
    bit we_prev = 0;
    int wr_w    = 0;
    int gap     = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (we && !we_prev) begin
                if (sb_q.size() == 0) begin
                    check(0, "R5", "unexpected write", int'(addr), -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(addr) == e.a, "R9", "write address", int'(addr), e.a);
                    if (e.ovw) check(int'(wdata) == e.d, "R6", "overwrite data", int'(wdata), e.d);
                    else       check(int'(wdata) == e.d, "R5", "sum data", int'(wdata), e.d);
                end
                check(fetch == 1'b1, "R7", "fetch with write", int'(fetch), 1);
                if (addr != '0)
                    check(gap == T_HLD + T_LAT + 1, "R8", "holdoff gap", gap, T_HLD + T_LAT + 1);
                wr_w = 1;
            end else if (we) begin
                wr_w++;
            end
            if (!we && we_prev) begin
                check(wr_w == T_WR, "R7", "write width", wr_w, T_WR);
                check(fetch == 1'b0, "R7", "fetch ends with write", int'(fetch), 0);
                gap = 1;
            end else if (!we) begin
                gap++;
            end
            we_prev = we;
        end
    end

    // driver: one complete run of LIM scans
    task automatic run(input int sel, input bit ovw, input int seed);
        int n;
        int cnt;
        int w;
        n         = DEPTH >> sel;
        size_sel  = 2'(sel);
        overwrite = ovw;
        @(negedge clk);
        start = 1'b1;
        cnt   = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end while (!arm && cnt < 1000);
        check(cnt == T_DLY + 1, "R3", "start to arm", cnt, T_DLY + 1);
        check(xfer == 1'b0, "R10", "start clears transfer request", int'(xfer), 0);
        for (int s = 1; s <= LIM; s++) begin
            w = 1;
            forever begin
                @(negedge clk);
                if (!arm) break;
                w++;
            end
            check(w == T_ARM, "R3", "arm width", w, T_ARM);
            check(ready == 1'b0, "R11", "busy during scan", int'(ready), 0);
            repeat (2) @(negedge clk);
            rec_busy = 1'b1;
            repeat (3) @(negedge clk);
            check(outreq == 1'b0, "R4", "no request while recording", int'(outreq), 0);
            rec_busy = 1'b0;
            @(negedge clk);
            check(outreq == 1'b1, "R4", "request after record end", int'(outreq), 1);
            for (int i = 0; i < n; i++) begin
                logic [SW-1:0] smp;
                exp_t e;
                smp      = SW'(i * 7 + s * 13 + seed * 5);
                model[i] = ovw ? DW'(smp) : model[i] + DW'(smp);
                e.a = i; e.d = int'(model[i]); e.ovw = ovw;
                sb_q.push_back(e);
                sample = smp;
                flag   = 1'b1;
                do @(negedge clk); while (!fetch);
                flag = 1'b0;
                do @(negedge clk); while (fetch);
                if (i < n - 1)
                    check(outreq == 1'b1, "R9", "request held mid scan", int'(outreq), 1);
                else
                    check(outreq == 1'b0, "R9", "request drops at wrap", int'(outreq), 0);
            end
            if (s < LIM) begin
                check(xfer == 1'b0, "R10", "no transfer before limit", int'(xfer), 0);
                cnt = 0;
                while (!arm) begin
                    @(negedge clk);
                    cnt++;
                end
                check(cnt == T_DLY, "R9", "re-arm delay", cnt, T_DLY);
            end else begin
                check(xfer == 1'b1, "R10", "transfer at limit", int'(xfer), 1);
                check(ready == 1'b1, "R11", "idle after limit", int'(ready), 1);
                cnt = 0;
                repeat (10) begin
                    @(negedge clk);
                    if (arm) cnt++;
                end
                check(cnt == 0, "R10", "no re-arm after limit", cnt, 0);
                check(xfer == 1'b1, "R10", "transfer held", int'(xfer), 1);
            end
        end
        check(sb_q.size() == 0, "R5", "all writes seen", sb_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int armed;
        rst_n = 1'b0; start = 1'b0; attn = 1'b0; overwrite = 1'b0;
        rec_busy = 1'b0; flag = 1'b0; size_sel = 2'd0; sample = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(arm == 1'b0 && outreq == 1'b0, "R1", "arm/request idle", int'(arm) + int'(outreq), 0);
        check(we == 1'b0 && fetch == 1'b0, "R1", "write/fetch idle", int'(we) + int'(fetch), 0);
        check(xfer == 1'b0, "R1", "transfer idle", int'(xfer), 0);
        check(addr == '0, "R1", "address zero", int'(addr), 0);

        // R2: start under attention is ignored
        attn  = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        armed = 0;
        repeat (15) begin
            @(negedge clk);
            if (arm) armed++;
        end
        check(armed == 0, "R2", "no arm under attention", armed, 0);
        check(ready == 1'b1, "R2", "stays idle under attention", int'(ready), 1);
        attn = 1'b0;

        run(2, 1'b0, 1);
        run(3, 1'b1, 2);
        run(3, 1'b0, 3);
        run(0, 1'b0, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule